// File: doc/BRIEF.md
# Configurable Trace Byte Output Port

This block moves a stream of trace bytes off the chip through one of three pin protocols, chosen at run time. The first protocol is a clocked parallel port of 1, 2 or 4 data pins with a forwarded clock. The second sends each byte serially on one pin with Manchester coding. The third sends it on the same pin as a UART-style NRZ frame. All timing is taken from the trace clock `clk`. The two serial protocols rely on that clock staying at a constant frequency, because their bit time is a fixed count of its cycles.

A small zero-wait APB slave holds three settings: the protocol, the one-hot port width and a 12-bit serial bit-time prescaler. The slave only works while the global trace enable `trc_en` is high. While it is low, reads return zero and writes do nothing.

Bytes arrive on a valid/ready stream. A byte is taken on a rising edge where `in_valid` and `in_ready` are both high. The producer must hold `in_valid` and `in_data` stable until that edge. `in_ready` stays low while a byte is still being sent, which back-pressures the source. Register changes are sampled only when a byte is accepted, so a byte already in flight always completes with the settings it started with.

Top module: `trace_port_unit`

## Requirements
- R1: The protocol register sits at offset 0x0F0, bits [1:0]. Code 00 selects the parallel port, 01 Manchester and 10 NRZ. It resets to 01. A write of 11, or a write with any bit above bit 1 set, leaves the register unchanged.
- R2: The width register sits at offset 0x004, bits [3:0], and resets to 0x1. Bit 0 selects 1 pin, bit 1 selects 2 pins and bit 3 selects 4 pins. A write is ignored if it is zero, not one-hot, sets bit 2, or sets any bit above bit 3.
- R3: In parallel mode a byte leaves LSB first, one chunk of the selected width per trace-clock cycle, on `par_data` low pins. A byte takes 8, 4 or 2 cycles. `par_clk` inverts on every edge while the protocol is parallel or a parallel byte is in flight.
- R4: In Manchester mode each half-bit lasts max(prescale/2, 1) cycles. A 1 is sent as high then low, a 0 as low then high, bits LSB first. The line rests low after the byte.
- R5: While `trc_en` is low, `prdata` is zero for every address.
- R6: While `trc_en` is low, writes to any register have no effect.
- R7: In NRZ mode each bit lasts max(prescale, 1) cycles. The frame is a low start bit, then 8 data bits LSB first, then a high stop bit. The line rests high when idle.
- R8: The prescaler sits at offset 0x010, bits [11:0], and resets to 16. A write with any bit above bit 11 set is ignored.
- R9: `in_ready` falls on the edge that accepts a byte. In parallel mode it rises in the cycle of the last chunk. In serial mode it rises when the last symbol ends.
- R10: Protocol and width are sampled only when a byte is accepted. A register change made mid-byte alters neither that byte nor its pins. The pins of the protocol not in use stay at rest (`par_data` zero during serial bytes).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Trace clock; all state moves on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| trc_en | input | 1 | Global trace enable; gates register access |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | 12 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| in_valid | input | 1 | Trace byte offered |
| in_data | input | 8 | Trace byte |
| in_ready | output | 1 | Unit can take a byte this edge |
| par_data | output | 4 | Parallel trace data pins |
| par_clk | output | 1 | Forwarded trace clock, half the input rate |
| ser_out | output | 1 | Single-pin serial trace output |

## Verification
The bench checks every output cycle of each byte against a model built from the requirements. A chunk order or shift step that is off shows up as wrong pin values, and a half-bit length or polarity error shows up as misplaced Manchester or NRZ edges. It writes illegal width codes (zero, two bits set, the unsupported bit 2), the reserved protocol code and writes made with the enable low. A design that takes any of them loses its settings, and a following read-back exposes this. It also switches protocol in the middle of an NRZ frame. A design that applied the change at once would corrupt the frame or start parallel chunks early. The bench also tracks `in_ready` on each cycle, so releasing it one cycle too early or too late is caught.

// File: rtl/tpu_pkg.sv
package tpu_pkg;

  typedef enum logic [1:0] {
    PROTO_PAR   = 2'b00,
    PROTO_MANCH = 2'b01,
    PROTO_NRZ   = 2'b10
  } proto_e;

  localparam int unsigned PINS      = 4;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned MANCH_SYM = 2 * BYTE_W;
  localparam int unsigned NRZ_SYM   = BYTE_W + 2;

  // Expand a byte into half-bit symbols, LSB first: 1 -> (1,0), 0 -> (0,1)
  function automatic logic [MANCH_SYM-1:0] manch_expand(input logic [BYTE_W-1:0] b);
    logic [MANCH_SYM-1:0] s;
    for (int i = 0; i < BYTE_W; i++) begin
      s[2*i]   = b[i];
      s[2*i+1] = ~b[i];
    end
    return s;
  endfunction

endpackage

// File: rtl/tpu_regs.sv
module tpu_regs
  import tpu_pkg::*;
#(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned PRE_W   = 12,
  parameter int unsigned PRE_RST = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trc_en,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output proto_e            proto,
  output logic [1:0]        wcode,
  output logic [PRE_W-1:0]  prescale
);

  localparam logic [ADDR_W-1:0] A_SIZE  = ADDR_W'(12'h004);
  localparam logic [ADDR_W-1:0] A_PROTO = ADDR_W'(12'h0F0);
  localparam logic [ADDR_W-1:0] A_PRE   = ADDR_W'(12'h010);

  logic [3:0]       size_q;
  proto_e           proto_q;
  logic [PRE_W-1:0] pre_q;
  logic             wr;
  logic             size_ok, proto_ok, pre_ok;

  assign wr = psel && penable && pwrite && trc_en;

  assign size_ok  = (pwdata[DATA_W-1:4] == '0) && ($countones(pwdata[3:0]) == 1) && !pwdata[2];
  assign proto_ok = (pwdata[DATA_W-1:2] == '0) && (pwdata[1:0] != 2'b11);
  assign pre_ok   = (pwdata[DATA_W-1:PRE_W] == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q  <= 4'b0001;
      proto_q <= PROTO_MANCH;
      pre_q   <= PRE_W'(PRE_RST);
    end else if (wr) begin
      if (paddr == A_SIZE && size_ok)   size_q  <= pwdata[3:0];
      if (paddr == A_PROTO && proto_ok) proto_q <= proto_e'(pwdata[1:0]);
      if (paddr == A_PRE && pre_ok)     pre_q   <= pwdata[PRE_W-1:0];
    end
  end

  always_comb begin
    prdata = '0;
    if (psel && trc_en) begin
      unique case (paddr)
        A_SIZE:  prdata = DATA_W'(size_q);
        A_PROTO: prdata = DATA_W'(proto_q);
        A_PRE:   prdata = DATA_W'(pre_q);
        default: prdata = '0;
      endcase
    end
  end

  // width code: 0 -> 1 pin, 1 -> 2 pins, 2 -> 4 pins
  always_comb begin
    if (size_q[3])      wcode = 2'd2;
    else if (size_q[1]) wcode = 2'd1;
    else                wcode = 2'd0;
  end

  assign proto    = proto_q;
  assign prescale = pre_q;

  p_size_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(size_q) && !size_q[2]);
  p_proto_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    proto_q != 2'b11);
  p_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !trc_en |=> $stable(size_q) && $stable(proto_q) && $stable(pre_q));

endmodule

// File: rtl/tpu_par_tx.sv
module tpu_par_tx
  import tpu_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [7:0]      data,
  input  logic [1:0]      wcode,
  input  logic            clk_run,
  output logic [PINS-1:0] pins,
  output logic            fclk,
  output logic            busy
);

  logic [7:0]      sh_q;
  logic [1:0]      wc_q;
  logic [2:0]      left_q;
  logic [PINS-1:0] pins_q;
  logic            busy_q;
  logic            fclk_q;

  function automatic logic [PINS-1:0] chunk(input logic [7:0] v, input logic [1:0] wc);
    logic [PINS-1:0] r;
    unique case (wc)
      2'd2:    r = v[3:0];
      2'd1:    r = {2'b00, v[1:0]};
      default: r = {3'b000, v[0]};
    endcase
    return r;
  endfunction

  function automatic logic [7:0] shift_out(input logic [7:0] v, input logic [1:0] wc);
    return v >> (1 << wc);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      wc_q   <= '0;
      left_q <= '0;
      pins_q <= '0;
      busy_q <= 1'b0;
    end else if (start) begin
      pins_q <= chunk(data, wcode);
      sh_q   <= shift_out(data, wcode);
      wc_q   <= wcode;
      left_q <= 3'((8 >> wcode) - 1);
      busy_q <= 1'b1;
    end else if (busy_q) begin
      pins_q <= chunk(sh_q, wc_q);
      sh_q   <= shift_out(sh_q, wc_q);
      left_q <= left_q - 3'd1;
      if (left_q == 3'd1) busy_q <= 1'b0;
    end else begin
      pins_q <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  fclk_q <= 1'b0;
    else if (clk_run || busy_q)  fclk_q <= ~fclk_q;
  end

  assign pins = pins_q;
  assign fclk = fclk_q;
  assign busy = busy_q;

  p_fclk_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> fclk_q != $past(fclk_q));
  p_pins_rest_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !start) |=> pins_q == '0);

endmodule

// File: rtl/tpu_ser_tx.sv
module tpu_ser_tx
  import tpu_pkg::*;
#(
  parameter int unsigned PRE_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             manch,
  input  logic [7:0]       data,
  input  logic [PRE_W-1:0] prescale,
  input  logic             idle_hi,
  output logic             ser,
  output logic             busy
);

  localparam int unsigned CNT_W = $clog2(MANCH_SYM + 1);

  logic [MANCH_SYM-1:0] pat_q;
  logic [CNT_W-1:0]     left_q;
  logic [PRE_W-1:0]     tmr_q, len_q;
  logic [PRE_W-1:0]     len_full, len_half, len_sel;
  logic [MANCH_SYM-1:0] pat_new;
  logic                 ser_q, busy_q;

  assign len_full = (prescale == '0) ? PRE_W'(1) : prescale;
  assign len_half = ((prescale >> 1) == '0) ? PRE_W'(1) : (prescale >> 1);
  assign len_sel  = manch ? len_half : len_full;
  assign pat_new  = manch ? manch_expand(data)
                          : MANCH_SYM'({1'b1, data, 1'b0});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pat_q  <= '0;
      left_q <= '0;
      tmr_q  <= '0;
      len_q  <= '0;
      ser_q  <= 1'b0;
      busy_q <= 1'b0;
    end else if (start) begin
      ser_q  <= pat_new[0];
      pat_q  <= pat_new >> 1;
      left_q <= manch ? CNT_W'(MANCH_SYM) : CNT_W'(NRZ_SYM);
      len_q  <= len_sel;
      tmr_q  <= len_sel - PRE_W'(1);
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (tmr_q != '0) begin
        tmr_q <= tmr_q - PRE_W'(1);
      end else if (left_q == CNT_W'(1)) begin
        busy_q <= 1'b0;
        ser_q  <= idle_hi;
      end else begin
        ser_q  <= pat_q[0];
        pat_q  <= pat_q >> 1;
        left_q <= left_q - CNT_W'(1);
        tmr_q  <= len_q - PRE_W'(1);
      end
    end else begin
      ser_q <= idle_hi;
    end
  end

  assign ser  = ser_q;
  assign busy = busy_q;

  p_sym_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !start && tmr_q != '0) |=> $stable(ser_q));
  p_len_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !start) |=> $stable(len_q));

endmodule

// File: rtl/trace_port_unit.sv
module trace_port_unit
  import tpu_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        trc_en,
  input  logic        psel,
  input  logic        penable,
  input  logic        pwrite,
  input  logic [11:0] paddr,
  input  logic [31:0] pwdata,
  output logic [31:0] prdata,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  output logic        in_ready,
  output logic [3:0]  par_data,
  output logic        par_clk,
  output logic        ser_out
);

  localparam int unsigned PRE_W = 12;

  proto_e           proto;
  logic [1:0]       wcode;
  logic [PRE_W-1:0] prescale;
  logic             take, par_start, ser_start;
  logic             par_busy, ser_busy;

  tpu_regs #(
    .ADDR_W(12), .DATA_W(32), .PRE_W(PRE_W), .PRE_RST(16)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .trc_en(trc_en),
    .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .proto(proto), .wcode(wcode), .prescale(prescale)
  );

  assign in_ready  = !par_busy && !ser_busy;
  assign take      = in_valid && in_ready;
  assign par_start = take && (proto == PROTO_PAR);
  assign ser_start = take && (proto != PROTO_PAR);

  tpu_par_tx u_par (
    .clk(clk), .rst_n(rst_n), .start(par_start), .data(in_data),
    .wcode(wcode), .clk_run(proto == PROTO_PAR),
    .pins(par_data), .fclk(par_clk), .busy(par_busy)
  );

  tpu_ser_tx #(.PRE_W(PRE_W)) u_ser (
    .clk(clk), .rst_n(rst_n), .start(ser_start),
    .manch(proto == PROTO_MANCH), .data(in_data),
    .prescale(prescale), .idle_hi(proto == PROTO_NRZ),
    .ser(ser_out), .busy(ser_busy)
  );

  p_take_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !in_ready);
  p_one_engine_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(par_busy && ser_busy));

endmodule

// File: tb/tb_trace_port_unit.sv
module tb_trace_port_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trc_en = 1'b1;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_ready;
  logic [3:0]  par_data;
  logic        par_clk, ser_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  trace_port_unit dut (
    .clk(clk), .rst_n(rst_n), .trc_en(trc_en),
    .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .par_data(par_data), .par_clk(par_clk), .ser_out(ser_out)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic apb_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk); penable = 1; #1 d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  // kind: 0 parallel, 1 Manchester, 2 NRZ; len = symbol cycles; wc = width code
  task automatic stream_byte(input logic [7:0] b, input int kind, input int len,
                             input int wc, input logic idle_exp, input string req);
    int total;
    logic prev_clk;
    @(negedge clk); in_valid = 1; in_data = b;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    prev_clk = par_clk;
    total = (kind == 0) ? (8 >> wc) : ((kind == 1) ? 16 * len : 10 * len);
    for (int m = 0; m < total; m++) begin
      @(negedge clk);
      in_valid = 0;
      if (kind == 0) begin
        int w = 1 << wc;
        logic [3:0] e = 4'((b >> (m * w)) & ((1 << w) - 1));
        chk(par_data == e, req, "parallel chunk", par_data, e);
        chk(par_clk != prev_clk, "R3", "par_clk toggle", par_clk, ~prev_clk);
        prev_clk = par_clk;
        chk(in_ready == (m == total - 1), "R9", "ready in parallel byte", in_ready, m == total - 1);
      end else begin
        int j = m / len;
        logic e;
        if (kind == 1) e = (j % 2 == 0) ? b[j/2] : ~b[j/2];
        else e = (j == 0) ? 1'b0 : ((j == 9) ? 1'b1 : b[j-1]);
        chk(ser_out == e, req, "serial symbol", ser_out, e);
        chk(in_ready == 1'b0, "R9", "ready in serial frame", in_ready, 0);
        chk(par_data == 4'h0, "R10", "parallel pins rest", par_data, 0);
      end
    end
    @(negedge clk);
    if (kind == 0) chk(par_data == 4'h0, "R3", "par_data after byte", par_data, 0);
    else begin
      chk(ser_out == idle_exp, req, "serial idle level", ser_out, idle_exp);
      chk(in_ready == 1'b1, "R9", "ready after frame", in_ready, 1);
    end
  endtask

  task automatic t_reset;
    logic [31:0] d;
    @(negedge clk);
    chk(par_data == 0 && ser_out == 0 && par_clk == 0, "R1", "outputs at reset", {par_data, par_clk, ser_out}, 0);
    chk(in_ready == 1, "R9", "ready at reset", in_ready, 1);
    apb_rd(12'h0F0, d); chk(d == 32'h1, "R1", "protocol reset", d, 32'h1);
    apb_rd(12'h004, d); chk(d == 32'h1, "R2", "width reset", d, 32'h1);
    apb_rd(12'h010, d); chk(d == 32'd16, "R8", "prescale reset", d, 32'd16);
  endtask

  task automatic t_enable_gate;
    logic [31:0] d;
    trc_en = 0;
    apb_rd(12'h0F0, d); chk(d == 0, "R5", "read while disabled", d, 0);
    apb_rd(12'h010, d); chk(d == 0, "R5", "read while disabled", d, 0);
    apb_wr(12'h0F0, 32'h2);
    apb_wr(12'h004, 32'h8);
    trc_en = 1;
    apb_rd(12'h0F0, d); chk(d == 32'h1, "R6", "protocol after locked write", d, 32'h1);
    apb_rd(12'h004, d); chk(d == 32'h1, "R6", "width after locked write", d, 32'h1);
  endtask

  task automatic t_reg_rules;
    logic [31:0] d;
    apb_wr(12'h004, 32'h2);
    apb_wr(12'h004, 32'h4); apb_rd(12'h004, d); chk(d == 32'h2, "R2", "bit2 rejected", d, 32'h2);
    apb_wr(12'h004, 32'h3); apb_rd(12'h004, d); chk(d == 32'h2, "R2", "two bits rejected", d, 32'h2);
    apb_wr(12'h004, 32'h0); apb_rd(12'h004, d); chk(d == 32'h2, "R2", "zero rejected", d, 32'h2);
    apb_wr(12'h004, 32'h18); apb_rd(12'h004, d); chk(d == 32'h2, "R2", "upper bits rejected", d, 32'h2);
    apb_wr(12'h004, 32'h8); apb_rd(12'h004, d); chk(d == 32'h8, "R2", "width 4 accepted", d, 32'h8);
    apb_wr(12'h0F0, 32'h3); apb_rd(12'h0F0, d); chk(d == 32'h1, "R1", "reserved code rejected", d, 32'h1);
    apb_wr(12'h010, 32'h1004); apb_rd(12'h010, d); chk(d == 32'd16, "R8", "wide prescale rejected", d, 32'd16);
    apb_wr(12'h010, 32'h4); apb_rd(12'h010, d); chk(d == 32'h4, "R8", "prescale accepted", d, 32'h4);
  endtask

  task automatic t_parallel;
    apb_wr(12'h0F0, 32'h0);
    apb_wr(12'h004, 32'h1); stream_byte(8'hB4, 0, 1, 0, 1'b0, "R3");
    apb_wr(12'h004, 32'h2); stream_byte(8'h6C, 0, 1, 1, 1'b0, "R3");
    apb_wr(12'h004, 32'h8); stream_byte(8'hD2, 0, 1, 2, 1'b0, "R3");
    stream_byte(8'h1F, 0, 1, 2, 1'b0, "R3");
  endtask

  task automatic t_nrz;
    apb_wr(12'h0F0, 32'h2);
    apb_wr(12'h010, 32'h4);
    stream_byte(8'h3C, 2, 4, 0, 1'b1, "R7");
    apb_wr(12'h010, 32'h0);
    stream_byte(8'hA1, 2, 1, 0, 1'b1, "R7");
  endtask

  task automatic t_manch;
    apb_wr(12'h0F0, 32'h1);
    apb_wr(12'h010, 32'h6);
    stream_byte(8'hA5, 1, 3, 0, 1'b0, "R4");
    apb_wr(12'h010, 32'h1);
    stream_byte(8'h81, 1, 1, 0, 1'b0, "R4");
  endtask

  task automatic t_boundary;
    apb_wr(12'h0F0, 32'h2);
    apb_wr(12'h010, 32'h4);
    apb_wr(12'h004, 32'h2);
    fork
      stream_byte(8'h5A, 2, 4, 0, 1'b0, "R10");
      begin
        repeat (6) @(negedge clk);
        apb_wr(12'h0F0, 32'h0);
      end
    join
    stream_byte(8'hC9, 0, 1, 1, 1'b0, "R10");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_enable_gate();
    t_reg_rules();
    t_parallel();
    t_nrz();
    t_manch();
    t_boundary();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule